// File: doc/BRIEF.md
# Prescaled Cycle Counter

This block is a 64-bit cycle counter for a performance-monitoring unit. Each clock, while enabled, it adds a per-cycle delta to its value. A divide-by-64 mode makes it advance by one for every 64 units of accumulated delta. A 6-bit remainder register carries the part of the delta that has not yet been counted from one cycle to the next, and that remainder is cleared whenever the divide setting changes.

The surrounding logic can clear the value to zero with a one-cycle pulse or load a new value directly. The counter reports wrap-around through a sticky status flag and a one-cycle interrupt request. The wrap point is chosen between bit 31 and bit 63. The counter can be read as a full 64-bit value or as its low 32 bits. Its event type is fixed to processor cycles, code 0x11, and cannot be changed.

Top module: `prescaled_cycle_counter`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `rd_full` and `rd_low` read 0, and `ovf_flag` and `irq_req` are 0.
- R2: With `div_mode`=0, each enabled cycle with no load and no zero pulse adds `delta` to the value, modulo 2^64. The new value is visible after that clock edge.
- R3: With `div_mode`=1, each enabled cycle forms `remainder + delta`. The value advances by that sum shifted right by 6, and the remainder keeps the sum's low 6 bits.
- R4: In a cycle where `div_mode` differs from its value in the previous cycle, the remainder is treated as zero before the add. Remainder left over from the earlier mode never reaches the count.
- R5: With `cnt_en`=0, and no load or zero pulse, neither the value nor the remainder changes.
- R6: `load_en` takes priority over `zero_pulse`, and both take priority over the increment. A load writes `load_val`, and a zero pulse writes 0.
- R7: A wrap is detected when the monitored bit goes from 1 to 0 on an increment. The monitored bit is bit 63 when `wide_ovf`=1 and bit 31 when `wide_ovf`=0.
- R8: A wrap sets `ovf_flag` only if the flag is clear. In that case, and only if `irq_en`=1, `irq_req` is high for exactly the following cycle. `ovf_clr` clears the flag.
- R9: `rd_full` returns the whole 64-bit value, and `rd_low` returns bits 31:0 of it.
- R10: `evt_type` always reads 0x11, the processor-cycle event code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counting enable |
| div_mode | input | 1 | Divide-by-64 setting from the control register |
| wide_ovf | input | 1 | 1: wrap at bit 63, 0: wrap at bit 31 |
| delta | input | DELTA_W | Per-cycle increment |
| zero_pulse | input | 1 | Clear the value to zero |
| load_en | input | 1 | Load `load_val` into the value |
| load_val | input | CNT_W | Value to load |
| irq_en | input | 1 | Interrupt enable for this counter |
| ovf_clr | input | 1 | Clear the wrap status flag |
| rd_full | output | CNT_W | Full counter value |
| rd_low | output | LOW_W | Low half of the counter value |
| ovf_flag | output | 1 | Sticky wrap status |
| irq_req | output | 1 | One-cycle interrupt request |
| evt_type | output | EVT_W | Fixed event type code |

## Verification
The bench builds the block with its defaults: a 64-bit count, a 32-bit low view and an 8-bit delta. An 8-bit delta lets a single add carry the remainder across one or more multiples of 64, so in divide mode the bench can see advances of 0, 1 and 4 in one cycle. The 64-bit count lets the bench load values just below both wrap points and watch carries pass through bit 31 in either wrap setting.

// File: rtl/prescaled_cycle_counter.sv
module prescaled_cycle_counter #(
  parameter int CNT_W      = 64,
  parameter int LOW_W      = 32,
  parameter int DELTA_W    = 8,
  parameter int REM_W      = 6,
  parameter int EVT_W      = 8,
  parameter logic [EVT_W-1:0] EVT_CYCLES = 8'h11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_en,
  input  logic               div_mode,
  input  logic               wide_ovf,
  input  logic [DELTA_W-1:0] delta,
  input  logic               zero_pulse,
  input  logic               load_en,
  input  logic [CNT_W-1:0]   load_val,
  input  logic               irq_en,
  input  logic               ovf_clr,
  output logic [CNT_W-1:0]   rd_full,
  output logic [LOW_W-1:0]   rd_low,
  output logic               ovf_flag,
  output logic               irq_req,
  output logic [EVT_W-1:0]   evt_type
);
  localparam int SUM_W = ((DELTA_W > REM_W) ? DELTA_W : REM_W) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [REM_W-1:0] rem_q;
  logic             div_q;
  logic             ovf_q;
  logic             irq_q;

  wire              div_chg  = div_mode ^ div_q;
  wire [REM_W-1:0]  rem_base = div_chg ? '0 : rem_q;
  wire [SUM_W-1:0]  rem_sum  = SUM_W'(rem_base) + SUM_W'(delta);
  wire [CNT_W-1:0]  step     = div_mode ? CNT_W'(rem_sum >> REM_W) : CNT_W'(delta);
  wire [CNT_W-1:0]  cnt_inc  = cnt_q + step;
  wire              inc_go   = cnt_en && !load_en && !zero_pulse;
  wire              top_old  = wide_ovf ? cnt_q[CNT_W-1]   : cnt_q[LOW_W-1];
  wire              top_new  = wide_ovf ? cnt_inc[CNT_W-1] : cnt_inc[LOW_W-1];
  wire              wrap     = inc_go && top_old && !top_new;
  wire              new_ovf  = wrap && !ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rem_q <= '0;
      div_q <= 1'b0;
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      div_q <= div_mode;
      if (load_en)         cnt_q <= load_val;
      else if (zero_pulse) cnt_q <= '0;
      else if (cnt_en)     cnt_q <= cnt_inc;
      if (inc_go && div_mode) rem_q <= rem_sum[REM_W-1:0];
      else                    rem_q <= rem_base;
      if (new_ovf)      ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
      irq_q <= new_ovf && irq_en;
    end
  end

  assign rd_full  = cnt_q;
  assign rd_low   = cnt_q[LOW_W-1:0];
  assign ovf_flag = ovf_q;
  assign irq_req  = irq_q;
  assign evt_type = EVT_CYCLES;
endmodule

// File: rtl/prescaled_cycle_counter_chk.sv
module prescaled_cycle_counter_chk #(
  parameter int CNT_W   = 64,
  parameter int LOW_W   = 32,
  parameter int DELTA_W = 8,
  parameter int EVT_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cnt_en,
  input logic               div_mode,
  input logic               wide_ovf,
  input logic [DELTA_W-1:0] delta,
  input logic               zero_pulse,
  input logic               load_en,
  input logic [CNT_W-1:0]   load_val,
  input logic               irq_en,
  input logic               ovf_clr,
  input logic [CNT_W-1:0]   rd_full,
  input logic [LOW_W-1:0]   rd_low,
  input logic               ovf_flag,
  input logic               irq_req,
  input logic [EVT_W-1:0]   evt_type
);
  // R6
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> rd_full == $past(load_val));

  // R6
  zero_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_pulse && !load_en) |=> rd_full == '0);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !load_en && !zero_pulse) |=> $stable(rd_full));

  // R2
  plain_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !div_mode && !load_en && !zero_pulse)
      |=> rd_full == $past(rd_full) + CNT_W'($past(delta)));

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ovf_flag);

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);

  // R7
  ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(cnt_en) && !$past(load_en) && !$past(zero_pulse));
endmodule

bind prescaled_cycle_counter prescaled_cycle_counter_chk #(
  .CNT_W(CNT_W), .LOW_W(LOW_W), .DELTA_W(DELTA_W), .EVT_W(EVT_W)
) chk_i (.*);

// File: tb/prescaled_cycle_counter_tb_top.sv
module prescaled_cycle_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0, div_mode = 1'b0, wide_ovf = 1'b0;
  logic [7:0]  delta = '0;
  logic        zero_pulse = 1'b0, load_en = 1'b0, irq_en = 1'b0, ovf_clr = 1'b0;
  logic [63:0] load_val = '0;
  logic [63:0] rd_full;
  logic [31:0] rd_low;
  logic        ovf_flag, irq_req;
  logic [7:0]  evt_type;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prescaled_cycle_counter dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .div_mode(div_mode),
    .wide_ovf(wide_ovf), .delta(delta), .zero_pulse(zero_pulse),
    .load_en(load_en), .load_val(load_val), .irq_en(irq_en),
    .ovf_clr(ovf_clr), .rd_full(rd_full), .rd_low(rd_low),
    .ovf_flag(ovf_flag), .irq_req(irq_req), .evt_type(evt_type)
  );

  // {cnt_en, div_mode, delta, expected value after the edge}
  localparam logic [73:0] VEC [0:12] = '{
    {1'b1, 1'b0, 8'd5,   64'd5},
    {1'b1, 1'b0, 8'd200, 64'd205},
    {1'b0, 1'b0, 8'd7,   64'd205},
    {1'b1, 1'b1, 8'd40,  64'd205},
    {1'b1, 1'b1, 8'd30,  64'd206},
    {1'b1, 1'b1, 8'd255, 64'd210},
    {1'b0, 1'b1, 8'd100, 64'd210},
    {1'b1, 1'b1, 8'd58,  64'd210},
    {1'b1, 1'b1, 8'd1,   64'd211},
    {1'b1, 1'b1, 8'd63,  64'd211},
    {1'b1, 1'b0, 8'd3,   64'd214},
    {1'b1, 1'b1, 8'd1,   64'd214},
    {1'b1, 1'b1, 8'd63,  64'd215}
  };

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    load_en = 1'b0; zero_pulse = 1'b0; ovf_clr = 1'b0;
  endtask

  task automatic load(input logic [63:0] v);
    load_val = v; load_en = 1'b1; cnt_en = 1'b0;
    tick();
  endtask

  task automatic inc(input logic [7:0] d);
    cnt_en = 1'b1; delta = d;
    tick();
    cnt_en = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 value in reset", rd_full, 64'd0);
    chk("R1 flag in reset", {62'd0, ovf_flag, irq_req}, 64'd0);
    rst_n = 1'b1;
    tick();
    chk("R1 value after reset", rd_full, 64'd0);
    chk("R10 event code", {56'd0, evt_type}, 64'h11);

    // R2 R3 R4 R5 vector walk
    for (int i = 0; i < 13; i++) begin
      cnt_en = VEC[i][73]; div_mode = VEC[i][72]; delta = VEC[i][71:64];
      tick();
      chk($sformatf("R2/R3/R4/R5 vector %0d", i), rd_full, VEC[i][63:0]);
    end
    cnt_en = 1'b0; div_mode = 1'b0;
    tick();

    // R6 load beats zero and increment; R9 low view
    load_val = 64'h1234_5678_9ABC_DEF0; load_en = 1'b1; zero_pulse = 1'b1;
    cnt_en = 1'b1; delta = 8'd9;
    tick();
    cnt_en = 1'b0;
    chk("R6 load priority", rd_full, 64'h1234_5678_9ABC_DEF0);
    chk("R9 low half", {32'd0, rd_low}, 64'h9ABC_DEF0);
    zero_pulse = 1'b1; cnt_en = 1'b1; delta = 8'd9;
    tick();
    cnt_en = 1'b0;
    chk("R6 zero over increment", rd_full, 64'd0);

    // R7 R8 narrow wrap with interrupt
    wide_ovf = 1'b0; irq_en = 1'b1;
    load(64'hFFFF_FFFE);
    inc(8'd3);
    chk("R7 narrow wrap value", rd_full, 64'h1_0000_0001);
    chk("R7 narrow wrap flag", {63'd0, ovf_flag}, 64'd1);
    chk("R8 irq raised", {63'd0, irq_req}, 64'd1);
    tick();
    chk("R8 irq one cycle", {63'd0, irq_req}, 64'd0);
    load(64'h1_FFFF_FFFF);
    inc(8'd1);
    chk("R8 no irq while flagged", {63'd0, irq_req}, 64'd0);
    chk("R8 flag sticky", {63'd0, ovf_flag}, 64'd1);
    ovf_clr = 1'b1;
    tick();
    chk("R8 flag cleared", {63'd0, ovf_flag}, 64'd0);

    // R7 no false wrap; R8 irq disabled
    irq_en = 1'b0;
    load(64'h7FFF_FFFF);
    inc(8'd1);
    chk("R7 rising bit no wrap", {63'd0, ovf_flag}, 64'd0);
    load(64'hFFFF_FFFF);
    inc(8'd1);
    chk("R8 flag with irq off", {63'd0, ovf_flag}, 64'd1);
    chk("R8 no irq when disabled", {63'd0, irq_req}, 64'd0);
    ovf_clr = 1'b1;
    tick();

    // R7 wide wrap point
    wide_ovf = 1'b1; irq_en = 1'b1;
    load(64'hFFFF_FFFF);
    inc(8'd1);
    chk("R7 wide ignores bit 31", {63'd0, ovf_flag}, 64'd0);
    chk("R9 wide carry value", rd_full, 64'h1_0000_0000);
    load(64'hFFFF_FFFF_FFFF_FFFE);
    inc(8'd3);
    chk("R7 wide wrap value", rd_full, 64'd1);
    chk("R7 wide wrap flag", {63'd0, ovf_flag}, 64'd1);
    chk("R8 wide irq", {63'd0, irq_req}, 64'd1);
    chk("R10 event code unchanged", {56'd0, evt_type}, 64'h11);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule